// File: doc/BRIEF.md
# Power-Mode Supervisor State Machine

This block is the mode controller of a system supervisor that powers and watches a microcontroller. It keeps the current operating mode (Init, Normal, Stop, Sleep, Restart or Fail-Safe). It moves between these modes on decoded mode requests from the serial control port, wake events, watchdog failures, supply-undervoltage resets and thermal-shutdown flags. Every event input is a single-cycle strobe that is already synchronised to `clk`. The watchdog timer, the serial shifter, the regulators and the bus transceiver sit outside the block.

The outputs are an active-low reset for the microcontroller, an active-low interrupt pulse, the mode code, a sticky request-error flag and the current watchdog period code. The block refuses illegal entries into low-power modes. It keeps a minimum dwell in Fail-Safe and stores wakes that arrive during that dwell. After repeated undervoltage resets with no clean recovery between them, it escalates to Fail-Safe. All delays are parameters counted in clock cycles.

Top module: `pwr_mode_sup`

## Requirements
- R1: After power-on reset the mode is Init (code 3'b000). In that state `rst_out_n`=1, `int_n`=1, `req_err`=0 and `wd_period`=3'b100. The mode codes are Init 000, Normal 001, Stop 010, Sleep 011, Restart 100 and Fail-Safe 101.
- R2: In Init, any request strobe moves the block to Normal on the next edge, whatever the code, and does not set `req_err`. Wake strobes in Init are discarded: no interrupt and no mode change.
- R3: In Init, if no `wd_kick` arrives for LONG_WIN cycles the block goes to Restart. Each `wd_kick` restarts that window.
- R4: In Normal and Stop the request codes are: 000 Normal, 001 Stop, 010 Sleep, 011 back to Init. Codes 1xx set `req_err` and leave the mode unchanged. `req_err` stays set until a legal request is accepted.
- R5: A Sleep request (010) made in Stop is refused. It sets `req_err` and the block enters Restart.
- R6: A Sleep request made in Normal while `wake_any_en`=0 sets `req_err` and the block enters Restart.
- R7: If `wake_pending` is high in Sleep, the block leaves for Restart on the next edge. A `wake_evt` in Sleep also leads to Restart.
- R8: In Normal and Stop, a `wake_evt` drives `int_n` low for exactly INT_LEN cycles and leaves the mode unchanged.
- R9: `rst_out_n` is low for the whole of Restart. Restart lasts RST_DLY cycles and then the block goes to Normal. Entering Restart reloads `wd_period` to 3'b100. A `wd_fail` in Normal or Stop enters Restart.
- R10: A `tsd_evt` in any mode other than Fail-Safe enters Fail-Safe with a dwell of FS_LONG cycles. Entry by undervoltage escalation uses FS_SHORT cycles. `rst_out_n` is low in Fail-Safe.
- R11: Fail-Safe is not left before its dwell ends. A wake seen during the dwell is stored and causes an exit to Restart when the dwell ends. After a thermal entry, a low `tsd_active` once the dwell has ended also causes the exit.
- R12: A `uv_rst` in Init, Normal, Stop or Restart enters (or restarts) Restart. The UV_LIMIT-th one in a row enters Fail-Safe instead. The count clears when a Restart completes into Normal.
- R13: `wd_period` takes `wd_per_val` on `wd_per_wr` only in Normal. In any other mode the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| req_valid | input | 1 | Mode request strobe |
| req_code | input | 3 | Mode request code |
| wd_kick | input | 1 | Watchdog trigger strobe |
| wd_fail | input | 1 | Watchdog failure strobe |
| wd_per_wr | input | 1 | Watchdog period write strobe |
| wd_per_val | input | 3 | Watchdog period code to write |
| wake_evt | input | 1 | Wake event strobe |
| wake_pending | input | 1 | Some wake status flag is still set |
| wake_any_en | input | 1 | At least one wake source is enabled |
| uv_rst | input | 1 | Supply undervoltage reset strobe |
| tsd_evt | input | 1 | Thermal shutdown strobe |
| tsd_active | input | 1 | Thermal condition still present |
| mode | output | 3 | Current mode code |
| rst_out_n | output | 1 | Reset to the controller, active low |
| int_n | output | 1 | Interrupt pulse, active low |
| req_err | output | 1 | Sticky request-error flag |
| wd_period | output | 3 | Current watchdog period code |

## Verification
The hardest situation to reach is undervoltage escalation, because the consecutive count clears whenever a Restart finishes. The stimulus therefore delivers all four `uv_rst` strobes inside a single Restart, well before its delay runs out. It then lets one Restart complete and sends three more, to show that the count began again. The stored wake in Fail-Safe is also hard to reach: the wake is pulsed early in the dwell and is then removed, and the mode is sampled just before and just after the dwell boundary.

// File: rtl/pwr_mode_sup.sv
module pwr_mode_sup #(
  parameter int LONG_WIN = 200,
  parameter int RST_DLY  = 16,
  parameter int FS_LONG  = 400,
  parameter int FS_SHORT = 100,
  parameter int INT_LEN  = 4,
  parameter int UV_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_code,
  input  logic       wd_kick,
  input  logic       wd_fail,
  input  logic       wd_per_wr,
  input  logic [2:0] wd_per_val,
  input  logic       wake_evt,
  input  logic       wake_pending,
  input  logic       wake_any_en,
  input  logic       uv_rst,
  input  logic       tsd_evt,
  input  logic       tsd_active,
  output logic [2:0] mode,
  output logic       rst_out_n,
  output logic       int_n,
  output logic       req_err,
  output logic [2:0] wd_period
);

  localparam logic [2:0] M_INIT = 3'd0, M_NORM = 3'd1, M_STOP = 3'd2,
                         M_SLEEP = 3'd3, M_RSTR = 3'd4, M_FAIL = 3'd5;
  localparam logic [2:0] WD_DEFAULT = 3'b100;
  localparam int M1   = (LONG_WIN > RST_DLY) ? LONG_WIN : RST_DLY;
  localparam int M2   = (FS_LONG > FS_SHORT) ? FS_LONG : FS_SHORT;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int IW   = $clog2(INT_LEN + 1);
  localparam int UW   = $clog2(UV_LIMIT + 1);
  localparam logic [TW-1:0] WIN_END  = TW'(LONG_WIN - 1);
  localparam logic [TW-1:0] RST_END  = TW'(RST_DLY - 1);
  localparam logic [TW-1:0] FSL_END  = TW'(FS_LONG - 1);
  localparam logic [TW-1:0] FSS_END  = TW'(FS_SHORT - 1);
  localparam logic [TW-1:0] TMR_MAX  = TW'(MAXC);
  localparam logic [UW-1:0] UV_LAST  = UW'(UV_LIMIT - 1);

  logic [2:0]    st, nxt;
  logic [TW-1:0] tmr;
  logic [IW-1:0] int_cnt;
  logic [UW-1:0] uv_cnt;
  logic          fs_thermal, wake_held;
  logic          err_set, err_clr, tmr_clr;

  wire awake_mode = (st == M_NORM) || (st == M_STOP);
  wire uv_hit = uv_rst && (awake_mode || st == M_INIT || st == M_RSTR);
  wire dwell_done = fs_thermal ? (tmr >= FSL_END) : (tmr >= FSS_END);

  always_comb begin
    nxt = st;
    err_set = 1'b0;
    err_clr = 1'b0;
    case (st)
      M_INIT: begin
        if (req_valid) nxt = M_NORM;
        else if (!wd_kick && tmr == WIN_END) nxt = M_RSTR;
      end
      M_NORM, M_STOP: begin
        if (wd_fail) nxt = M_RSTR;
        else if (req_valid) begin
          if (req_code[2]) err_set = 1'b1;
          else begin
            case (req_code[1:0])
              2'd0: nxt = M_NORM;
              2'd1: nxt = M_STOP;
              2'd2: begin
                if (st == M_STOP || !wake_any_en) begin
                  err_set = 1'b1;
                  nxt = M_RSTR;
                end else nxt = M_SLEEP;
              end
              default: nxt = M_INIT;
            endcase
            err_clr = !err_set;
          end
        end
      end
      M_SLEEP: if (wake_evt || wake_pending) nxt = M_RSTR;
      M_RSTR:  if (tmr == RST_END) nxt = M_NORM;
      M_FAIL:  if (dwell_done && (wake_held || wake_evt || (fs_thermal && !tsd_active)))
                 nxt = M_RSTR;
      default: nxt = M_INIT;
    endcase
    if (uv_hit) nxt = (uv_cnt == UV_LAST) ? M_FAIL : M_RSTR;
    if (tsd_evt && st != M_FAIL) nxt = M_FAIL;
  end

  assign tmr_clr = (nxt != st) || uv_hit || (st == M_INIT && wd_kick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= M_INIT;
      tmr        <= '0;
      int_cnt    <= '0;
      uv_cnt     <= '0;
      fs_thermal <= 1'b0;
      wake_held  <= 1'b0;
      req_err    <= 1'b0;
      wd_period  <= WD_DEFAULT;
    end else begin
      st <= nxt;
      if (tmr_clr) tmr <= '0;
      else if (tmr != TMR_MAX) tmr <= tmr + 1'b1;

      if (wake_evt && awake_mode) int_cnt <= IW'(INT_LEN);
      else if (int_cnt != '0) int_cnt <= int_cnt - 1'b1;

      if (uv_hit) uv_cnt <= (uv_cnt == UV_LAST) ? '0 : uv_cnt + 1'b1;
      else if (st == M_RSTR && nxt == M_NORM) uv_cnt <= '0;

      if (nxt == M_FAIL && st != M_FAIL) begin
        fs_thermal <= tsd_evt;
        wake_held  <= 1'b0;
      end else if (st == M_FAIL && wake_evt) wake_held <= 1'b1;

      if (err_set) req_err <= 1'b1;
      else if (err_clr) req_err <= 1'b0;

      if ((nxt == M_RSTR && st != M_RSTR) || (nxt == M_INIT && st != M_INIT))
        wd_period <= WD_DEFAULT;
      else if (st == M_NORM && wd_per_wr)
        wd_period <= wd_per_val;
    end
  end

  assign mode      = st;
  assign rst_out_n = !(st == M_RSTR || st == M_FAIL);
  assign int_n     = (int_cnt == '0);

  assert_stop_sleep_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_STOP && req_valid && req_code == 3'b010 && !wd_fail && !uv_rst && !tsd_evt)
      |=> (st == M_RSTR && req_err));

  assert_sleep_only_from_normal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_SLEEP && $past(st) != M_SLEEP) |-> ($past(st) == M_NORM && $past(wake_any_en)));

  assert_wake_keeps_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_NORM && wake_evt && !req_valid && !wd_fail && !uv_rst && !tsd_evt)
      |=> (st == M_NORM && !int_n));

  assert_restart_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_RSTR) |=> (st == M_RSTR || st == M_NORM || st == M_FAIL));

  assert_restart_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_RSTR) |-> (wd_period == WD_DEFAULT && !rst_out_n));

  assert_int_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> ($past(wake_evt) && ($past(st) == M_NORM || $past(st) == M_STOP)));

  assert_fail_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_FAIL && !dwell_done) |=> (st == M_FAIL));

  always_comb assert_uv_bound_R12: assert (uv_cnt < UW'(UV_LIMIT));

endmodule

// File: tb/tb_pwr_mode_sup.sv
module tb_pwr_mode_sup;
  localparam int LW = 40, RD = 8, FL = 60, FS = 20, IL = 3, UL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, wd_kick = 0, wd_fail = 0, wd_per_wr = 0;
  logic [2:0] req_code = 0, wd_per_val = 0;
  logic wake_evt = 0, wake_pending = 0, wake_any_en = 1;
  logic uv_rst = 0, tsd_evt = 0, tsd_active = 0;
  logic [2:0] mode, wd_period;
  logic rst_out_n, int_n, req_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_mode_sup #(.LONG_WIN(LW), .RST_DLY(RD), .FS_LONG(FL), .FS_SHORT(FS),
                 .INT_LEN(IL), .UV_LIMIT(UL)) dut (
    .clk, .rst_n, .req_valid, .req_code, .wd_kick, .wd_fail, .wd_per_wr,
    .wd_per_val, .wake_evt, .wake_pending, .wake_any_en, .uv_rst, .tsd_evt,
    .tsd_active, .mode, .rst_out_n, .int_n, .req_err, .wd_period);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    wait_n(3);
    rst_n = 1;
  endtask

  task automatic send_req(input logic [2:0] c);
    req_valid = 1; req_code = c;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic strobe_wake();
    wake_evt = 1; @(negedge clk); wake_evt = 0;
  endtask

  task automatic strobe_uv();
    uv_rst = 1; @(negedge clk); uv_rst = 0;
  endtask

  task automatic go_normal();
    do_reset();
    send_req(3'b000);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 mode", mode, 0);
    chk("R1 rst_out_n", rst_out_n, 1);
    chk("R1 int_n", int_n, 1);
    chk("R1 req_err", req_err, 0);
    chk("R1 wd_period", wd_period, 4);
  endtask

  task automatic t_init();
    do_reset();
    strobe_wake();
    chk("R2 wake ignored mode", mode, 0);
    chk("R2 wake ignored int_n", int_n, 1);
    send_req(3'b111);
    chk("R2 any request to Normal", mode, 1);
    chk("R2 no req_err in Init", req_err, 0);
  endtask

  task automatic t_window();
    do_reset();
    wait_n(20);
    chk("R3 still Init mid window", mode, 0);
    wait_n(22);
    chk("R3 window expiry to Restart", mode, 4);
    do_reset();
    wait_n(30);
    wd_kick = 1; @(negedge clk); wd_kick = 0;
    wait_n(30);
    chk("R3 kick restarts window", mode, 0);
    wait_n(15);
    chk("R3 expiry after kick", mode, 4);
  endtask

  task automatic t_codes();
    go_normal();
    send_req(3'b001);
    chk("R4 code 001 Stop", mode, 2);
    send_req(3'b000);
    chk("R4 code 000 Normal", mode, 1);
    send_req(3'b101);
    chk("R4 undefined keeps mode", mode, 1);
    chk("R4 undefined sets req_err", req_err, 1);
    send_req(3'b000);
    chk("R4 legal request clears req_err", req_err, 0);
    send_req(3'b011);
    chk("R4 code 011 Init", mode, 0);
  endtask

  task automatic t_stop_sleep();
    go_normal();
    send_req(3'b001);
    send_req(3'b010);
    chk("R5 Stop to Sleep gives Restart", mode, 4);
    chk("R5 req_err", req_err, 1);
  endtask

  task automatic t_sleep_nowake();
    go_normal();
    wake_any_en = 0;
    send_req(3'b010);
    chk("R6 no wake source Restart", mode, 4);
    chk("R6 req_err", req_err, 1);
    wake_any_en = 1;
  endtask

  task automatic t_sleep_wake();
    go_normal();
    wake_pending = 1;
    send_req(3'b010);
    chk("R7 Sleep entered", mode, 3);
    @(negedge clk);
    chk("R7 pending wake leaves Sleep", mode, 4);
    wake_pending = 0;
    go_normal();
    send_req(3'b010);
    wait_n(5);
    chk("R7 Sleep holds", mode, 3);
    strobe_wake();
    chk("R7 wake in Sleep to Restart", mode, 4);
    wait_n(RD);
    chk("R7 Restart then Normal", mode, 1);
  endtask

  task automatic t_int();
    go_normal();
    strobe_wake();
    chk("R8 int_n low first", int_n, 0);
    chk("R8 mode kept Normal", mode, 1);
    wait_n(IL - 1);
    chk("R8 int_n low last", int_n, 0);
    @(negedge clk);
    chk("R8 int_n released", int_n, 1);
    send_req(3'b001);
    strobe_wake();
    chk("R8 int_n low in Stop", int_n, 0);
    chk("R8 mode kept Stop", mode, 2);
  endtask

  task automatic t_restart();
    go_normal();
    wd_per_wr = 1; wd_per_val = 3'b010; @(negedge clk); wd_per_wr = 0;
    chk("R13 period write in Normal", wd_period, 2);
    wd_fail = 1; @(negedge clk); wd_fail = 0;
    chk("R9 wd_fail to Restart", mode, 4);
    chk("R9 period reload", wd_period, 4);
    chk("R9 rst_out_n low", rst_out_n, 0);
    wait_n(RD - 1);
    chk("R9 Restart held", mode, 4);
    @(negedge clk);
    chk("R9 Restart exits to Normal", mode, 1);
    chk("R9 rst_out_n released", rst_out_n, 1);
    send_req(3'b001);
    wd_per_wr = 1; wd_per_val = 3'b001; @(negedge clk); wd_per_wr = 0;
    chk("R13 period write ignored in Stop", wd_period, 4);
  endtask

  task automatic t_thermal();
    go_normal();
    tsd_active = 1;
    tsd_evt = 1; @(negedge clk); tsd_evt = 0;
    chk("R10 thermal to Fail-Safe", mode, 5);
    chk("R10 rst_out_n low", rst_out_n, 0);
    wait_n(10);
    strobe_wake();
    wait_n(FL - 13);
    chk("R11 dwell holds with stored wake", mode, 5);
    wait_n(3);
    chk("R11 stored wake exits after long dwell", mode, 4);
    wait_n(RD + 2);
    tsd_evt = 1; @(negedge clk); tsd_evt = 0;
    wait_n(FL + 10);
    chk("R11 stays while thermal active", mode, 5);
    tsd_active = 0;
    @(negedge clk);
    chk("R11 thermal release exits", mode, 4);
  endtask

  task automatic t_uv();
    go_normal();
    strobe_uv();
    chk("R12 uv to Restart", mode, 4);
    strobe_uv();
    strobe_uv();
    chk("R12 third uv still Restart", mode, 4);
    strobe_uv();
    chk("R12 fourth uv to Fail-Safe", mode, 5);
    strobe_wake();
    wait_n(FS - 3);
    chk("R10 short dwell holds", mode, 5);
    wait_n(3);
    chk("R10 short dwell ends to Restart", mode, 4);
    wait_n(RD + 2);
    chk("R12 recovered to Normal", mode, 1);
    strobe_uv();
    wait_n(RD + 2);
    chk("R12 single uv recovers", mode, 1);
    strobe_uv();
    strobe_uv();
    strobe_uv();
    chk("R12 count cleared by recovery", mode, 4);
  endtask

  initial begin
    t_reset_state();
    t_init();
    t_window();
    t_codes();
    t_stop_sleep();
    t_sleep_nowake();
    t_sleep_wake();
    t_int();
    t_restart();
    t_thermal();
    t_uv();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule